// File: doc/BRIEF.md
# Super I/O Configuration Port

This block holds the configuration space of a legacy Super I/O device as seen from an 8-bit host I/O bus. The host reaches the space through two byte addresses: an index port that selects a configuration register and a data port that reads or writes it. The space starts out locked. It opens only after a fixed four-byte key is written to the index port, and it closes again when the host writes the lock bit of the control register.

Inside the open space, a device-select register chooses which logical device's register bank the upper indices reach. The chip identity and revision are read-only constants. Each logical device owns its own bank of byte registers. The bank of the GPIO device carries the 16-bit I/O base address of the GPIO ports, and the block drives that address out to the GPIO logic together with the current device number.

Host accesses are single-cycle strobes with no back-pressure. Every decoded read is answered exactly one cycle later with a one-cycle response pulse. Accesses to any other address are neither answered nor acted on.

Top module: `sio_cfg_port`

## Requirements
- R1: The space opens (cfg_unlocked high) one cycle after the bytes 0x87, 0x01, 0x55, 0x55 have been written in that order to the index port 0x2E. Idle cycles and accesses to other addresses may come between the key bytes.
- R2: While the space is locked, an index-port write that does not match the next expected key byte sends the key matcher back to its start. A new attempt must then begin again with 0x87.
- R3: While the space is locked, a data-port write changes nothing, and a read of either port returns 0xFF.
- R4: While the space is open, an index-port write stores the index, and an index-port read returns it. Every data-port access goes to the index most recently stored. Key writes made while the space is locked never change the stored index.
- R5: A data-port write to index 0x02 with bit 1 set locks the space from the next cycle. A write to index 0x02 with bit 1 clear, or an index-port write of any value, leaves the space open. Index 0x02 reads as 0x00.
- R6: Index 0x07 is a read/write 8-bit logical-device number, and it is driven on cur_ldn.
- R7: Index 0x20 reads the high byte of the chip ID (0x87 by default) and index 0x21 reads the low byte (0x28). Index 0x22 reads the 4-bit revision in bits 3:0 (0x3) with zeros above it. Writes to these three indices are ignored.
- R8: Indices 0x60 to 0x7F reach a bank of 32 bytes that is separate for each device number from 0 to 7. With a device number of 8 or more, those indices read 0x00 and ignore writes. All other unlisted indices read 0x00 and ignore writes.
- R9: gpio_base equals the byte at index 0x62 (high byte) followed by the byte at index 0x63 (low byte) of device 7's bank. It takes a new value on the cycle after the write.
- R10: io_rvalid is high for exactly one cycle, the cycle after a read strobe to 0x2E or 0x2F, and io_rdata carries the result during that cycle. A read of any other address gives no response.
- R11: Reset leaves the space locked, the stored index at 0, the device number at 0, every bank byte at 0, gpio_base at 0 and io_rvalid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rvalid is high |
| io_rvalid | output | 1 | Read response, one cycle after a decoded read |
| cfg_unlocked | output | 1 | High while the configuration space is open |
| cur_ldn | output | 8 | Current logical-device number |
| gpio_base | output | 16 | GPIO I/O base address from device 7's bank |

## Verification
A key matcher left in the wrong state shows up on cfg_unlocked: it opens early, opens late or never opens. This is visible one cycle after the fourth key byte. A stored index or device number that has gone wrong returns the wrong byte on the next data-port read, which appears on io_rdata one cycle after the strobe. A bank write that lands in the wrong device or at the wrong offset reaches gpio_base at once if device 7 is involved. In any other device it stays hidden until that byte is read back. For this reason the bench reads back every bank it writes and compares every output against its model on every cycle.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ID_HI  = 8'h20;
  localparam logic [7:0] IDX_ID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam int         LOCK_BIT   = 1;
  localparam logic [7:0] LOCKED_RD  = 8'hFF;

  typedef enum logic [2:0] {
    KEY_WAIT0 = 3'd0,
    KEY_WAIT1 = 3'd1,
    KEY_WAIT2 = 3'd2,
    KEY_WAIT3 = 3'd3,
    CFG_OPEN  = 3'd4
  } unlock_st_e;

  // Byte expected on the index port in each waiting state
  function automatic logic [7:0] key_at(unlock_st_e s);
    case (s)
      KEY_WAIT0: key_at = 8'h87;
      KEY_WAIT1: key_at = 8'h01;
      KEY_WAIT2: key_at = 8'h55;
      KEY_WAIT3: key_at = 8'h55;
      default:   key_at = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_host_decode.sv
module sio_host_decode #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h002F
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              idx_rd,
  output logic              dat_rd
);

  logic hit_idx;
  logic hit_dat;

  assign hit_idx = (io_addr == IDX_PORT);
  assign hit_dat = (io_addr == DATA_PORT);

  assign idx_wr = io_wr & hit_idx;
  assign dat_wr = io_wr & hit_dat;
  assign idx_rd = io_rd & hit_idx;
  assign dat_rd = io_rd & hit_dat;

endmodule

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       lock_req,
  output logic       unlocked
);

  unlock_st_e state_q;
  unlock_st_e state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == CFG_OPEN) begin
      if (lock_req) state_d = KEY_WAIT0;
    end else if (idx_wr) begin
      if (wdata == key_at(state_q)) state_d = unlock_st_e'(state_q + 3'd1);
      else                          state_d = KEY_WAIT0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_WAIT0;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == CFG_OPEN);

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LDN       = 8,
  parameter int          BANK_LO       = 'h60,
  parameter int          BANK_DEPTH    = 32,
  parameter logic [15:0] CHIP_ID       = 16'h8728,
  parameter logic [3:0]  CHIP_REV      = 4'h3,
  parameter int          GPIO_LDN      = 7,
  parameter int          GPIO_BASE_IDX = 'h62
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unlocked,
  input  logic        idx_wr,
  input  logic        dat_wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  index_q,
  output logic [7:0]  ldn_q,
  output logic [7:0]  rd_byte,
  output logic        lock_req,
  output logic [15:0] gpio_base
);

  localparam int         OW    = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam int         LW    = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
  localparam logic [7:0] LO_B  = 8'(BANK_LO);
  localparam logic [7:0] HI_B  = 8'(BANK_LO + BANK_DEPTH - 1);
  localparam logic [OW-1:0] GOFF_HI = OW'(GPIO_BASE_IDX - BANK_LO);
  localparam logic [OW-1:0] GOFF_LO = OW'(GPIO_BASE_IDX - BANK_LO + 1);

  logic          cfg_wr;
  logic          in_bank;
  logic          ldn_ok;
  logic [OW-1:0] off;
  logic [7:0]    bank_rd [NUM_LDN];

  assign cfg_wr  = unlocked & dat_wr;
  assign in_bank = (index_q >= LO_B) && (index_q <= HI_B);
  assign off     = OW'(index_q - LO_B);
  assign ldn_ok  = ({1'b0, ldn_q} < 9'(NUM_LDN));

  assign lock_req = cfg_wr && (index_q == IDX_CTRL) && wdata[LOCK_BIT];

  // Index is only captured while the space is open, so key bytes never land here
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  index_q <= '0;
    else if (unlocked && idx_wr) index_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ldn_q <= '0;
    else if (cfg_wr && (index_q == IDX_LDN))   ldn_q <= wdata;
  end

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
    logic [7:0] cells [BANK_DEPTH];
    logic       sel;

    assign sel = cfg_wr && in_bank && (ldn_q == 8'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < BANK_DEPTH; i++) cells[i] <= '0;
      end else if (sel) begin
        cells[off] <= wdata;
      end
    end

    assign bank_rd[g] = cells[off];

    if (g == GPIO_LDN) begin : g_gpio
      assign gpio_base = {cells[GOFF_HI], cells[GOFF_LO]};
    end
  end

  if (GPIO_LDN >= NUM_LDN) begin : g_no_gpio
    assign gpio_base = '0;
  end

  always_comb begin
    case (index_q)
      IDX_LDN:   rd_byte = ldn_q;
      IDX_ID_HI: rd_byte = CHIP_ID[15:8];
      IDX_ID_LO: rd_byte = CHIP_ID[7:0];
      IDX_REV:   rd_byte = {4'h0, CHIP_REV};
      default:   rd_byte = (in_bank && ldn_ok) ? bank_rd[ldn_q[LW-1:0]] : 8'h00;
    endcase
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT      = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_PORT     = 16'h002F,
  parameter int                NUM_LDN       = 8,
  parameter int                BANK_LO       = 'h60,
  parameter int                BANK_DEPTH    = 32,
  parameter logic [15:0]       CHIP_ID       = 16'h8728,
  parameter logic [3:0]        CHIP_REV      = 4'h3,
  parameter int                GPIO_LDN      = 7,
  parameter int                GPIO_BASE_IDX = 'h62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              cfg_unlocked,
  output logic [7:0]        cur_ldn,
  output logic [15:0]       gpio_base
);

  logic       idx_wr, dat_wr, idx_rd, dat_rd;
  logic       lock_req;
  logic [7:0] index_q;
  logic [7:0] rd_byte;

  sio_host_decode #(
    .ADDR_W   (ADDR_W),
    .IDX_PORT (IDX_PORT),
    .DATA_PORT(DATA_PORT)
  ) u_decode (
    .io_addr(io_addr),
    .io_wr  (io_wr),
    .io_rd  (io_rd),
    .idx_wr (idx_wr),
    .dat_wr (dat_wr),
    .idx_rd (idx_rd),
    .dat_rd (dat_rd)
  );

  sio_unlock_fsm u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .wdata   (io_wdata),
    .lock_req(lock_req),
    .unlocked(cfg_unlocked)
  );

  sio_reg_bank #(
    .NUM_LDN      (NUM_LDN),
    .BANK_LO      (BANK_LO),
    .BANK_DEPTH   (BANK_DEPTH),
    .CHIP_ID      (CHIP_ID),
    .CHIP_REV     (CHIP_REV),
    .GPIO_LDN     (GPIO_LDN),
    .GPIO_BASE_IDX(GPIO_BASE_IDX)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlocked (cfg_unlocked),
    .idx_wr   (idx_wr),
    .dat_wr   (dat_wr),
    .wdata    (io_wdata),
    .index_q  (index_q),
    .ldn_q    (cur_ldn),
    .rd_byte  (rd_byte),
    .lock_req (lock_req),
    .gpio_base(gpio_base)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= idx_rd | dat_rd;
      if (idx_rd | dat_rd) begin
        if (!cfg_unlocked) io_rdata <= LOCKED_RD;
        else if (idx_rd)   io_rdata <= index_q;
        else               io_rdata <= rd_byte;
      end
    end
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h002E,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h002F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rvalid,
  input logic              cfg_unlocked,
  input logic [7:0]        cur_ldn,
  input logic [15:0]       gpio_base
);

  logic port_hit;
  assign port_hit = (io_addr == IDX_PORT) || (io_addr == DATA_PORT);

  a_r3_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && port_hit && !cfg_unlocked) |=> (io_rvalid && io_rdata == 8'hFF));

  a_r10_rvalid_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_rd && port_hit));

  a_r1_open_follows_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(io_wr && io_addr == IDX_PORT && io_wdata == 8'h55));

  a_r5_close_on_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_unlocked) |-> $past(io_wr && io_addr == DATA_PORT && io_wdata[1]));

  a_r9_base_frozen_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked |=> $stable(gpio_base));

  a_r6_ldn_frozen_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked |=> $stable(cur_ldn));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W   (ADDR_W),
  .IDX_PORT (IDX_PORT),
  .DATA_PORT(DATA_PORT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .io_rvalid   (io_rvalid),
  .cfg_unlocked(cfg_unlocked),
  .cur_ldn     (cur_ldn),
  .gpio_base   (gpio_base)
);

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        cfg_unlocked;
  logic [7:0]  cur_ldn;
  logic [15:0] gpio_base;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_unlocked(cfg_unlocked), .cur_ldn(cur_ldn), .gpio_base(gpio_base)
  );

  // Behavioural reference model
  int m_key;            // 0..3 waiting for key byte, 4 = open
  int m_idx;
  int m_ldn;
  int m_mem [8][32];
  bit m_rvalid;
  int m_rdata;

  function automatic int key_byte(int k);
    case (k)
      0: return 'h87;
      1: return 'h01;
      default: return 'h55;
    endcase
  endfunction

  function automatic int model_read(int idx);
    if (idx == 'h07) return m_ldn;
    if (idx == 'h20) return 'h87;
    if (idx == 'h21) return 'h28;
    if (idx == 'h22) return 'h03;
    if (idx >= 'h60 && idx <= 'h7F) return (m_ldn < 8) ? m_mem[m_ldn][idx - 'h60] : 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_key = 0; m_idx = 0; m_ldn = 0; m_rvalid = 0; m_rdata = 0;
      for (int a = 0; a < 8; a++) for (int b = 0; b < 32; b++) m_mem[a][b] = 0;
    end else begin
      m_rvalid = io_rd && (io_addr == 16'h2E || io_addr == 16'h2F);
      if (m_rvalid) begin
        if (m_key != 4)              m_rdata = 'hFF;
        else if (io_addr == 16'h2E)  m_rdata = m_idx;
        else                         m_rdata = model_read(m_idx);
      end
      if (io_wr && io_addr == 16'h2E) begin
        if (m_key != 4) m_key = (int'(io_wdata) == key_byte(m_key)) ? m_key + 1 : 0;
        else            m_idx = io_wdata;
      end else if (io_wr && io_addr == 16'h2F && m_key == 4) begin
        if (m_idx == 'h02 && io_wdata[1]) m_key = 0;
        else if (m_idx == 'h07) m_ldn = io_wdata;
        else if (m_idx >= 'h60 && m_idx <= 'h7F && m_ldn < 8) m_mem[m_ldn][m_idx - 'h60] = io_wdata;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 cfg_unlocked", int'(cfg_unlocked), int'(m_key == 4));
      chk("R6 cur_ldn", int'(cur_ldn), m_ldn);
      chk("R9 gpio_base", int'(gpio_base), (m_mem[7][2] << 8) | m_mem[7][3]);
      chk("R10 io_rvalid", int'(io_rvalid), int'(m_rvalid));
      if (m_rvalid) chk("R4 io_rdata", int'(io_rdata), m_rdata);
    end
  end

  task automatic wr(logic [15:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output int v, output bit vld);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = int'(io_rdata);
    vld = io_rvalid;
  endtask

  task automatic unlock();
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    int v;
    bit vld;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 locked", int'(cfg_unlocked), 0);
    chk("R11 ldn", int'(cur_ldn), 0);
    chk("R11 gpio_base", int'(gpio_base), 0);
    chk("R11 rvalid", int'(io_rvalid), 0);

    // R3: locked space
    rd(16'h2F, v, vld); chk("R3 locked data read", v, 'hFF);
    rd(16'h2E, v, vld); chk("R3 locked index read", v, 'hFF);
    wr(16'h2F, 8'h05);
    chk("R3 locked write ignored", int'(cur_ldn), 0);

    // R2: broken key sequences
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h87); wr(16'h2E, 8'h01);
    wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
    chk("R2 restart needs 0x87", int'(cfg_unlocked), 0);
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h55); wr(16'h2E, 8'hAA);
    chk("R2 bad last byte", int'(cfg_unlocked), 0);

    // R1: correct key with gaps and a foreign access between bytes
    wr(16'h2E, 8'h87); @(negedge clk); wr(16'h2E, 8'h01);
    wr(16'h0080, 8'h00); wr(16'h2E, 8'h55);
    chk("R1 not yet open", int'(cfg_unlocked), 0);
    wr(16'h2E, 8'h55);
    chk("R1 open after key", int'(cfg_unlocked), 1);

    // R4: key bytes did not land in the index
    rd(16'h2E, v, vld); chk("R4 index untouched by key", v, 0);

    // R7: identity registers
    wr(16'h2E, 8'h20); rd(16'h2F, v, vld); chk("R7 id high", v, 'h87);
    wr(16'h2F, 8'h12); rd(16'h2F, v, vld); chk("R7 id write ignored", v, 'h87);
    wr(16'h2E, 8'h21); rd(16'h2F, v, vld); chk("R7 id low", v, 'h28);
    wr(16'h2E, 8'h22); rd(16'h2F, v, vld); chk("R7 revision", v, 'h03);
    rd(16'h2E, v, vld); chk("R4 index readback", v, 'h22);

    // R6 / R9: select GPIO device, program base
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h07);
    chk("R6 ldn write", int'(cur_ldn), 7);
    rd(16'h2F, v, vld); chk("R6 ldn read", v, 7);
    wr(16'h2E, 8'h62); wr(16'h2F, 8'hA5);
    wr(16'h2E, 8'h63); wr(16'h2F, 8'h0C);
    chk("R9 gpio_base", int'(gpio_base), 'hA50C);

    // R8: banking
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h03);
    wr(16'h2E, 8'h62); wr(16'h2F, 8'h11);
    rd(16'h2F, v, vld); chk("R8 bank 3 readback", v, 'h11);
    chk("R8 other bank untouched", int'(gpio_base), 'hA50C);
    wr(16'h2E, 8'h7F); wr(16'h2F, 8'h3C);
    rd(16'h2F, v, vld); chk("R8 top of bank", v, 'h3C);
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h07);
    wr(16'h2E, 8'h62); rd(16'h2F, v, vld); chk("R8 bank 7 kept", v, 'hA5);
    wr(16'h2E, 8'h7F); rd(16'h2F, v, vld); chk("R8 bank 7 top zero", v, 0);
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h09);
    wr(16'h2E, 8'h62); wr(16'h2F, 8'h77);
    rd(16'h2F, v, vld); chk("R8 absent device reads zero", v, 0);
    chk("R8 absent device write ignored", int'(gpio_base), 'hA50C);
    wr(16'h2E, 8'h50); wr(16'h2F, 8'h44);
    rd(16'h2F, v, vld); chk("R8 unmapped index", v, 0);

    // R10: undecoded read gives no response
    rd(16'h2D, v, vld); chk("R10 no response", int'(vld), 0);
    rd(16'h2F, v, vld); chk("R10 response", int'(vld), 1);
    @(negedge clk); chk("R10 single pulse", int'(io_rvalid), 0);

    // R5: locking
    wr(16'h2E, 8'h02);
    chk("R5 index write keeps open", int'(cfg_unlocked), 1);
    rd(16'h2F, v, vld); chk("R5 ctrl reads zero", v, 0);
    wr(16'h2F, 8'h01);
    chk("R5 bit1 clear keeps open", int'(cfg_unlocked), 1);
    wr(16'h2F, 8'h02);
    chk("R5 locked", int'(cfg_unlocked), 0);
    rd(16'h2F, v, vld); chk("R3 read after lock", v, 'hFF);
    wr(16'h2E, 8'h62); wr(16'h2F, 8'h00);
    chk("R3 base kept while locked", int'(gpio_base), 'hA50C);

    // R4: index persists across lock and key writes
    unlock();
    chk("R1 reopen", int'(cfg_unlocked), 1);
    rd(16'h2E, v, vld); chk("R4 index kept", v, 'h02);

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule